// File: doc/BRIEF.md
# Two-Level Address Translation Unit

This block converts 32-bit device virtual addresses from a DMA client into 39-bit physical addresses. A four-entry fully associative cache of recent translations answers repeated pages straight away. On a miss, a hardware walker makes two reads through a simple memory read port: first the root-level entry, then the leaf-level entry. It returns the composed physical address and installs the result in the cache. Table entries hold only a page frame number. They have no valid or permission bits, so every walk produces a translation, and unused slots are expected to point at a placeholder page.

Software uses a small register window at 0x4000 to control the block. It can load the root table frame number, flush every cached translation with a single write, and request a halt. While halt is requested, no new translation is accepted and the client's memory requests are gated off. The halted status bit reads back as set only once the walker is idle and the client reports nothing in flight.

The control state machine has six states. ST_IDLE accepts a request. On a cache hit it moves to ST_REPLY, and on a miss it moves to ST_L1_ADDR. ST_L1_ADDR holds the root read request until it is taken, then moves to ST_L1_DATA. ST_L1_DATA waits for read data, then moves to ST_L2_ADDR. ST_L2_ADDR holds the leaf read request until it is taken, then moves to ST_L2_DATA. ST_L2_DATA waits for data, then moves to ST_REPLY. ST_REPLY presents the response for one cycle and returns to ST_IDLE.

Top module: `xlate_top`

## Requirements
- R1: On a miss, the first memory read address is {root_frame[26:0], va[31:22], 2'b00}, where va[31:22] is the root index.
- R2: The second read address is {E1[26:0], va[21:12], 2'b00}, where E1 is the first read's data. Bits 31:27 of every entry are ignored.
- R3: The physical address returned is {E2[26:0], va[11:0]}, where E2 is the second read's data. xrsp_valid is high for exactly one cycle, the cycle after E2 arrives.
- R4: A request whose page is cached gets its response in the cycle after acceptance and makes no memory read.
- R5: The cache holds 4 pages and replaces entries round-robin. The replacement pointer starts at entry 0 after reset and after each flush.
- R6: A write to 0x4300 with bit 0 set drops all cached pages at once. A write there with bit 0 clear has no effect.
- R7: If a flush arrives while a walk is in progress, that walk's result is still returned, but it is not cached.
- R8: Register 0x4304 holds the 27-bit root frame number and reads back what was written.
- R9: Bit 0 of register 0x45DC is the halt request, and its reset value is 1. While it is set, xreq_ready is 0 and dma_req_out is 0.
- R10: Bit 0 of register 0x45E0 reads 1 only when halt is requested, no walk or reply is pending, and dma_busy is low. Otherwise it reads 0.
- R11: Only one translation is in progress at a time. A memory read request keeps its address stable until mrd_ready is seen.
- R12: After reset: xrsp_valid, mrd_valid and xreq_ready are 0, the root frame reads 0, and status reads 1. Unmapped register addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| xreq_valid | input | 1 | Translation request valid |
| xreq_ready | output | 1 | Request accepted at this edge if valid |
| xreq_vaddr | input | 32 | Device virtual address |
| xrsp_valid | output | 1 | One-cycle response strobe |
| xrsp_paddr | output | 39 | Translated physical address |
| mrd_valid | output | 1 | Table read request |
| mrd_ready | input | 1 | Memory accepts the read |
| mrd_addr | output | 39 | Byte address of the table entry |
| mrd_rvalid | input | 1 | Read data strobe |
| mrd_rdata | input | 32 | Table entry |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 16 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| dma_req_in | input | 1 | Client memory request |
| dma_busy | input | 1 | Client has an access in flight |
| dma_req_out | output | 1 | Gated client memory request |

## Verification
A corrupted cache entry or a stale valid bit shows up at the response itself. It produces a wrong physical address, or a hit-timed reply (in the cycle after acceptance) where a miss should have cost two memory reads. The bench therefore checks both the address and the read count for every request. A wrong replacement pointer only shows on the request after the next eviction. So directed sequences fill all four entries, evict one, and probe every survivor. A walker state error appears within a few cycles as a wrong read address, a missing response, or a status bit that reads halted while a walk is still pending.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
    localparam int VA_W     = 32;
    localparam int PG_SHIFT = 12;
    localparam int IDX_W    = 10;
    localparam int VPN_W    = 2 * IDX_W;
    localparam int PPN_W    = 27;
    localparam int PA_W     = PPN_W + PG_SHIFT;
    localparam int PTE_W    = 32;
    localparam int CFG_AW   = 16;
    localparam int CFG_DW   = 32;

    localparam logic [CFG_AW-1:0] CFG_WINDOW = 16'h4000;
    localparam logic [11:0] OFS_FLUSH = 12'h300;
    localparam logic [11:0] OFS_ROOT  = 12'h304;
    localparam logic [11:0] OFS_HALT  = 12'h5DC;
    localparam logic [11:0] OFS_STAT  = 12'h5E0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_ADDR,
        ST_L1_DATA,
        ST_L2_ADDR,
        ST_L2_DATA,
        ST_REPLY
    } walk_st_e;

    typedef struct packed {
        logic             valid;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
    } tlb_ent_t;
endpackage

// File: rtl/xlate_cfg.sv
module xlate_cfg
    import xlate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CFG_AW-1:0] addr,
    input  logic [CFG_DW-1:0] wdata,
    input  logic              engine_idle,
    input  logic              dma_busy,
    output logic [CFG_DW-1:0] rdata,
    output logic [PPN_W-1:0]  root_ppn,
    output logic              halt_req,
    output logic              halted,
    output logic              flush
);
    localparam logic [CFG_AW-1:0] A_FLUSH = CFG_WINDOW + CFG_AW'(OFS_FLUSH);
    localparam logic [CFG_AW-1:0] A_ROOT  = CFG_WINDOW + CFG_AW'(OFS_ROOT);
    localparam logic [CFG_AW-1:0] A_HALT  = CFG_WINDOW + CFG_AW'(OFS_HALT);
    localparam logic [CFG_AW-1:0] A_STAT  = CFG_WINDOW + CFG_AW'(OFS_STAT);

    logic wdata_unused;
    assign wdata_unused = ^wdata[CFG_DW-1:PPN_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            root_ppn <= '0;
            halt_req <= 1'b1;
        end else if (wr_en) begin
            if (addr == A_ROOT) root_ppn <= wdata[PPN_W-1:0];
            if (addr == A_HALT) halt_req <= wdata[0];
        end
    end

    assign flush  = wr_en && (addr == A_FLUSH) && wdata[0];
    assign halted = halt_req && engine_idle && !dma_busy;

    always_comb begin
        rdata = '0;
        case (addr)
            A_ROOT:  rdata = CFG_DW'(root_ppn);
            A_HALT:  rdata = CFG_DW'(halt_req);
            A_STAT:  rdata = CFG_DW'(halted);
            default: rdata = '0;
        endcase
    end

    // R8: the root frame changes only on a write to its address
    p_root_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == A_ROOT) |=> $stable(root_ppn));
endmodule

// File: rtl/xlate_tlb.sv
module xlate_tlb
    import xlate_pkg::*;
#(
    parameter int N = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             hit,
    output logic [PPN_W-1:0] hit_ppn,
    input  logic             ins_en,
    input  logic [VPN_W-1:0] ins_vpn,
    input  logic [PPN_W-1:0] ins_ppn
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    tlb_ent_t        ent [N];
    logic [N-1:0]    hit_vec;
    logic [PW-1:0]   ptr;

    for (genvar i = 0; i < N; i++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent[i] <= '0;
            end else if (flush) begin
                ent[i].valid <= 1'b0;
            end else if (ins_en && ptr == PW'(i)) begin
                ent[i].valid <= 1'b1;
                ent[i].vpn   <= ins_vpn;
                ent[i].ppn   <= ins_ppn;
            end
        end
        assign hit_vec[i] = ent[i].valid && (ent[i].vpn == lk_vpn);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ptr <= '0;
        else if (flush)   ptr <= '0;
        else if (ins_en)  ptr <= (ptr == PW'(N-1)) ? '0 : ptr + 1'b1;
    end

    always_comb begin
        hit_ppn = '0;
        for (int k = 0; k < N; k++) begin
            if (hit_vec[k]) hit_ppn = hit_ppn | ent[k].ppn;
        end
    end
    assign hit = |hit_vec;

    // R5: a page is cached in at most one entry
    p_single_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
    // R6: after a flush nothing matches
    p_flush_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !hit);
    // R7: a fill never lands together with a flush
    p_no_fill_on_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(flush && ins_en));
endmodule

// File: rtl/xlate_walk.sv
module xlate_walk
    import xlate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_paddr,
    input  logic             halt_req,
    input  logic [PPN_W-1:0] root_ppn,
    input  logic             flush,
    input  logic             tlb_hit,
    input  logic [PPN_W-1:0] tlb_ppn,
    output logic             ins_en,
    output logic [VPN_W-1:0] ins_vpn,
    output logic [PPN_W-1:0] ins_ppn,
    output logic             mem_valid,
    input  logic             mem_ready,
    output logic [PA_W-1:0]  mem_addr,
    input  logic             mem_rvalid,
    input  logic [PTE_W-1:0] mem_rdata,
    output logic             idle
);
    walk_st_e         state, nxt;
    logic [VA_W-1:0]  va_q;
    logic [PPN_W-1:0] l1e_q;
    logic [PPN_W-1:0] ppn_q;
    logic             stale_q;
    logic             accept;
    logic             walking;
    logic             rdata_unused;

    assign rdata_unused = ^mem_rdata[PTE_W-1:PPN_W];
    assign accept  = req_valid && req_ready;
    assign walking = (state == ST_L1_ADDR) || (state == ST_L1_DATA) ||
                     (state == ST_L2_ADDR) || (state == ST_L2_DATA);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (accept)     nxt = tlb_hit ? ST_REPLY : ST_L1_ADDR;
            ST_L1_ADDR: if (mem_ready)  nxt = ST_L1_DATA;
            ST_L1_DATA: if (mem_rvalid) nxt = ST_L2_ADDR;
            ST_L2_ADDR: if (mem_ready)  nxt = ST_L2_DATA;
            ST_L2_DATA: if (mem_rvalid) nxt = ST_REPLY;
            ST_REPLY:                   nxt = ST_IDLE;
            default:                    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q    <= '0;
            l1e_q   <= '0;
            ppn_q   <= '0;
            stale_q <= 1'b0;
        end else begin
            if (state == ST_IDLE && accept) begin
                va_q    <= req_vaddr;
                stale_q <= 1'b0;
                if (tlb_hit) ppn_q <= tlb_ppn;
            end else if (walking && flush) begin
                stale_q <= 1'b1;
            end
            if (state == ST_L1_DATA && mem_rvalid) l1e_q <= mem_rdata[PPN_W-1:0];
            if (state == ST_L2_DATA && mem_rvalid) ppn_q <= mem_rdata[PPN_W-1:0];
        end
    end

    always_comb begin
        req_ready = (state == ST_IDLE) && !halt_req;
        idle      = (state == ST_IDLE);
        mem_valid = (state == ST_L1_ADDR) || (state == ST_L2_ADDR);
        if (state == ST_L1_ADDR)
            mem_addr = {root_ppn, va_q[VA_W-1 -: IDX_W], 2'b00};
        else
            mem_addr = {l1e_q, va_q[PG_SHIFT +: IDX_W], 2'b00};
        rsp_valid = (state == ST_REPLY);
        rsp_paddr = {ppn_q, va_q[PG_SHIFT-1:0]};
        ins_en    = (state == ST_L2_DATA) && mem_rvalid && !stale_q && !flush;
        ins_vpn   = va_q[VA_W-1:PG_SHIFT];
        ins_ppn   = mem_rdata[PPN_W-1:0];
    end

    // R4: an accepted hit replies in the next cycle
    p_hit_reply_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && tlb_hit) |=> (rsp_valid && !mem_valid));
    // R11: a read request holds until taken
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));
    // R3: final read data leads to a reply in the next cycle
    p_reply_after_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_L2_DATA && mem_rvalid) |=> rsp_valid);
endmodule

// File: rtl/xlate_top.sv
module xlate_top
    import xlate_pkg::*;
#(
    parameter int TLB_N = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xreq_valid,
    output logic              xreq_ready,
    input  logic [VA_W-1:0]   xreq_vaddr,
    output logic              xrsp_valid,
    output logic [PA_W-1:0]   xrsp_paddr,
    output logic              mrd_valid,
    input  logic              mrd_ready,
    output logic [PA_W-1:0]   mrd_addr,
    input  logic              mrd_rvalid,
    input  logic [PTE_W-1:0]  mrd_rdata,
    input  logic              cfg_wr,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    output logic [CFG_DW-1:0] cfg_rdata,
    input  logic              dma_req_in,
    input  logic              dma_busy,
    output logic              dma_req_out
);
    logic             halt_req, halted, flush, eng_idle;
    logic [PPN_W-1:0] root_ppn;
    logic             tlb_hit, ins_en;
    logic [PPN_W-1:0] tlb_ppn, ins_ppn;
    logic [VPN_W-1:0] ins_vpn;

    xlate_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .addr(cfg_addr),
        .wdata(cfg_wdata), .engine_idle(eng_idle), .dma_busy(dma_busy),
        .rdata(cfg_rdata), .root_ppn(root_ppn), .halt_req(halt_req),
        .halted(halted), .flush(flush)
    );

    xlate_tlb #(.N(TLB_N)) u_tlb (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_vpn(xreq_vaddr[VA_W-1:PG_SHIFT]), .hit(tlb_hit), .hit_ppn(tlb_ppn),
        .ins_en(ins_en), .ins_vpn(ins_vpn), .ins_ppn(ins_ppn)
    );

    xlate_walk u_walk (
        .clk(clk), .rst_n(rst_n),
        .req_valid(xreq_valid), .req_ready(xreq_ready), .req_vaddr(xreq_vaddr),
        .rsp_valid(xrsp_valid), .rsp_paddr(xrsp_paddr),
        .halt_req(halt_req), .root_ppn(root_ppn), .flush(flush),
        .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn),
        .ins_en(ins_en), .ins_vpn(ins_vpn), .ins_ppn(ins_ppn),
        .mem_valid(mrd_valid), .mem_ready(mrd_ready), .mem_addr(mrd_addr),
        .mem_rvalid(mrd_rvalid), .mem_rdata(mrd_rdata), .idle(eng_idle)
    );

    assign dma_req_out = dma_req_in && !halt_req;

    // R10: once halted, no table read and no reply is pending
    p_halted_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mrd_valid && !xrsp_valid && !xreq_ready));
endmodule

// File: tb/xlate_top_bench.sv
`timescale 1ns/1ps
module xlate_top_bench;
    localparam logic [15:0] A_FLUSH = 16'h4300;
    localparam logic [15:0] A_ROOT  = 16'h4304;
    localparam logic [15:0] A_HALT  = 16'h45DC;
    localparam logic [15:0] A_STAT  = 16'h45E0;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        xreq_valid = 1'b0, xreq_ready;
    logic [31:0] xreq_vaddr = '0;
    logic        xrsp_valid;
    logic [38:0] xrsp_paddr;
    logic        mrd_valid, mrd_ready = 1'b0;
    logic [38:0] mrd_addr;
    logic        mrd_rvalid = 1'b0;
    logic [31:0] mrd_rdata = '0;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        dma_req_in = 1'b0, dma_busy = 1'b0, dma_req_out;

    int n_cmp = 0, n_bad = 0;
    int rd_count = 0, served = 0;
    logic [38:0] last_a = '0, prev_a = '0;
    bit  pend = 0;
    int  lat = 0;

    logic [26:0] m_base = '0;
    logic [19:0] m_vpn [4];
    bit          m_val [4];
    int          m_ptr = 0;

    always #2.5 clk = ~clk;

    xlate_top u_xlate_top (
        .clk(clk), .rst_n(rst_n),
        .xreq_valid(xreq_valid), .xreq_ready(xreq_ready), .xreq_vaddr(xreq_vaddr),
        .xrsp_valid(xrsp_valid), .xrsp_paddr(xrsp_paddr),
        .mrd_valid(mrd_valid), .mrd_ready(mrd_ready), .mrd_addr(mrd_addr),
        .mrd_rvalid(mrd_rvalid), .mrd_rdata(mrd_rdata),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .dma_req_in(dma_req_in), .dma_busy(dma_busy), .dma_req_out(dma_req_out)
    );

    function automatic logic [31:0] pte_of(input logic [38:0] a);
        logic [38:0] h;
        h = (a * 39'd2654435761) ^ (a >> 7);
        return {5'b10110, h[33:7]};
    endfunction

    function automatic logic [38:0] exp_pa(input logic [31:0] va);
        logic [31:0] e1, e2;
        e1 = pte_of({m_base, va[31:22], 2'b00});
        e2 = pte_of({e1[26:0], va[21:12], 2'b00});
        return {e2[26:0], va[11:0]};
    endfunction

    function automatic bit mdl_hit(input logic [19:0] vpn);
        for (int i = 0; i < 4; i++) if (m_val[i] && m_vpn[i] == vpn) return 1'b1;
        return 1'b0;
    endfunction

    function automatic void mdl_flush();
        for (int i = 0; i < 4; i++) m_val[i] = 1'b0;
        m_ptr = 0;
    endfunction

    // memory model: record accepted reads at the edge
    always @(posedge clk) begin
        if (mrd_valid && mrd_ready) begin
            rd_count <= rd_count + 1;
            prev_a   <= last_a;
            last_a   <= mrd_addr;
        end
    end

    always @(negedge clk) begin
        mrd_rvalid = 1'b0;
        if (!pend && served != rd_count) begin
            pend = 1;
            lat  = $urandom_range(0, 2);
        end
        if (pend) begin
            if (lat == 0) begin
                mrd_rvalid = 1'b1;
                mrd_rdata  = pte_of(last_a);
                pend = 0;
                served++;
            end else lat--;
        end
        mrd_ready = ($urandom_range(0, 3) != 0);
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd_cfg(input logic [15:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    // mid: 0 none, 1 flush during walk, 2 halt during walk
    task automatic xlate(input logic [31:0] va, input int mid, input string req);
        int r0, cyc;
        bit eh;
        logic [38:0] ep;
        logic [31:0] st;
        eh = mdl_hit(va[31:12]);
        ep = exp_pa(va);
        r0 = rd_count;
        @(negedge clk);
        xreq_valid = 1'b1; xreq_vaddr = va;
        cyc = 0;
        while (!xreq_ready && cyc < 100) begin @(negedge clk); cyc++; end
        @(negedge clk);
        xreq_valid = 1'b0;
        if (mid != 0) begin
            cfg_wr = 1'b1;
            cfg_addr = (mid == 1) ? A_FLUSH : A_HALT;
            cfg_wdata = 32'd1;
            @(negedge clk);
            cfg_wr = 1'b0;
            if (mid == 2) begin
                rd_cfg(A_STAT, st);
                check("R10 status low while walk pending", 64'(st[0]), 64'd0);
            end
        end
        cyc = 0;
        while (!xrsp_valid && cyc < 200) begin @(negedge clk); cyc++; end
        check({req, " paddr"}, 64'(xrsp_paddr), 64'(ep));
        check({req, " response seen"}, 64'(xrsp_valid), 64'd1);
        if (eh) begin
            check("R4 hit latency", 64'(cyc), 64'd0);
            check("R4 hit makes no read", 64'(rd_count - r0), 64'd0);
        end else begin
            check({req, " miss makes two reads"}, 64'(rd_count - r0), 64'd2);
            if (mid == 1) mdl_flush();
            else begin
                m_vpn[m_ptr] = va[31:12];
                m_val[m_ptr] = 1'b1;
                m_ptr = (m_ptr + 1) % 4;
            end
        end
        @(negedge clk);
        check("R3 response is one cycle", 64'(xrsp_valid), 64'd0);
        if (mid == 2) begin
            rd_cfg(A_STAT, st);
            check("R10 status high after walk drains", 64'(st[0]), 64'd1);
            wr_cfg(A_HALT, 32'd0);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        logic [31:0] va;
        logic [19:0] pool [8];
        void'($urandom(32'd20240611));
        mdl_flush();
        dma_req_in = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        check("R12 xreq_ready after reset", 64'(xreq_ready), 64'd0);
        check("R12 xrsp_valid after reset", 64'(xrsp_valid), 64'd0);
        check("R12 mrd_valid after reset", 64'(mrd_valid), 64'd0);
        rd_cfg(A_ROOT, d);  check("R12 root after reset", 64'(d), 64'd0);
        rd_cfg(A_STAT, d);  check("R12 status after reset", 64'(d), 64'd1);
        rd_cfg(16'h4010, d); check("R12 unmapped reads zero", 64'(d), 64'd0);
        check("R9 gate closed at reset", 64'(dma_req_out), 64'd0);
        rd_cfg(A_HALT, d);  check("R9 halt resets to one", 64'(d), 64'd1);

        // root and halt registers
        m_base = 27'h12345;
        wr_cfg(A_ROOT, {5'b11111, m_base});
        rd_cfg(A_ROOT, d); check("R8 root readback", 64'(d), 64'(m_base));
        wr_cfg(A_HALT, 32'd0);
        rd_cfg(A_STAT, d); check("R10 status clear when running", 64'(d), 64'd0);
        #1 check("R9 gate open when running", 64'(dma_req_out), 64'd1);

        // directed miss then hit
        va = 32'hA5C3_7123;
        xlate(va, 0, "R3 first miss");
        check("R1 root entry address", 64'(prev_a), 64'({m_base, va[31:22], 2'b00}));
        d = pte_of({m_base, va[31:22], 2'b00});
        check("R2 leaf entry address", 64'(last_a), 64'({d[26:0], va[21:12], 2'b00}));
        xlate({va[31:12], 12'hFFF}, 0, "R4 repeat page");

        // round-robin replacement
        wr_cfg(A_FLUSH, 32'd1); mdl_flush();
        for (int i = 0; i < 4; i++) xlate({20'h10000 + 20'(i * 1031), 12'h0}, 0, "R5 fill");
        for (int i = 0; i < 4; i++) xlate({20'h10000 + 20'(i * 1031), 12'h44}, 0, "R5 all four cached");
        xlate({20'hFEDCB, 12'h8}, 0, "R5 evicts entry 0");
        xlate({20'h10000 + 20'd1031, 12'h9}, 0, "R5 survivor hits");
        xlate({20'h10000, 12'hA}, 0, "R5 evicted page misses");

        // flush with bit 0 clear is ignored
        wr_cfg(A_FLUSH, 32'd2);
        xlate({20'hFEDCB, 12'hB}, 0, "R6 ignored flush keeps page");
        wr_cfg(A_FLUSH, 32'd1); mdl_flush();
        xlate({20'hFEDCB, 12'hC}, 0, "R6 flush drops page");

        // flush during a walk
        wr_cfg(A_FLUSH, 32'd1); mdl_flush();
        xlate(32'h3333_3010, 1, "R7 walk with flush");
        xlate(32'h3333_3020, 0, "R7 result was not cached");

        // halt while walking, and halt with client busy
        xlate(32'h0777_7040, 2, "R10 walk with halt");
        dma_busy = 1'b1;
        wr_cfg(A_HALT, 32'd1);
        rd_cfg(A_STAT, d); check("R10 status low while client busy", 64'(d), 64'd0);
        dma_busy = 1'b0;
        #1 rd_cfg(A_STAT, d); check("R10 status high when client idle", 64'(d), 64'd1);
        begin
            int r0;
            bit seen;
            r0 = rd_count; seen = 0;
            @(negedge clk); xreq_valid = 1'b1; xreq_vaddr = 32'h5555_5000;
            repeat (6) begin @(negedge clk); if (xrsp_valid || xreq_ready) seen = 1; end
            xreq_valid = 1'b0;
            check("R9 no translation while halted", 64'(seen), 64'd0);
            check("R9 no read while halted", 64'(rd_count - r0), 64'd0);
            check("R9 gate closed while halted", 64'(dma_req_out), 64'd0);
        end
        wr_cfg(A_HALT, 32'd0);

        // random traffic
        for (int i = 0; i < 8; i++) pool[i] = 20'($urandom);
        for (int i = 0; i < 300; i++) begin
            int op;
            op = $urandom_range(0, 29);
            if (op == 0) begin
                wr_cfg(A_FLUSH, 32'd1); mdl_flush();
            end else if (op == 1) begin
                m_base = 27'($urandom);
                wr_cfg(A_ROOT, {5'b0, m_base});
                wr_cfg(A_FLUSH, 32'd1); mdl_flush();
            end
            xlate({pool[$urandom_range(0, 7)], 12'($urandom)}, 0, "R5 random traffic");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule